// File: doc/BRIEF.md
# Character LCD Write Controller

This block drives a two-line, sixteen-column character display over an 8-bit parallel bus. It uses three control lines: a register select, a read/write line and an enable strobe. The display takes a byte on the falling edge of the enable strobe. Register select tells it whether the byte is a command or a character to show. The controller only writes, so the read/write line never leaves the write level. Reading the display's busy flag is not supported. The controller waits a fixed, programmable number of cycles after each byte instead.

After reset the controller sends a fixed set-up sequence of four commands by itself. These set two lines with a 5x7 font, turn the display on with a blinking cursor, select auto-increment, and clear the display. After that, client logic sends one byte at a time on a valid/ready handshake. Each byte carries a flag that marks it as character data or as a command. A second flag turns the request into a cursor move. The controller then builds the cursor-address command from a row and a column input.

Every transfer runs through four timed phases. In setup the bus is driven with the strobe low. In pulse the strobe is high. In hold the bus is kept after the strobe falls. In wait the display is given time to execute. Clear and return-home commands are slower on the display, so they get a separate, longer wait.

Top module: `charlcd_writer`

## Requirements
- R1: `lcd_rs_o` is 0 while a command byte is on the bus and 1 while a character byte is on the bus (`req_data_i`=1 marks a character).
- R2: `lcd_rw_o` is 0 at all times, including during reset.
- R3: After reset the bus carries, in this order, the commands 0x38, 0x0F, 0x06, 0x01 before any client byte. `req_ready_o` stays 0 until the last of these has finished its wait.
- R4: The enable strobe stays high for exactly PULSE_CYC cycles. `lcd_db_o` and `lcd_rs_o` do not change from SETUP_CYC cycles before the strobe rises until HOLD_CYC cycles after it falls.
- R5: A cursor request (`req_pos_i`=1) sends the command 0x80 + column for row 0 (`req_row_i`=0) or 0xC0 + column for row 1.
- R6: A cursor request whose column is above 15 is sent as column 15.
- R7: With requests queued back to back, consecutive strobe falls are HOLD_CYC + WAIT_CYC + 1 + SETUP_CYC + PULSE_CYC cycles apart.
- R8: After a command byte 0x01 or 0x02, LONG_WAIT_CYC replaces WAIT_CYC in that spacing. A character byte with the same value uses the normal wait.
- R9: `req_ready_o` is 0 from the cycle after a request is accepted until that transfer's wait has ended. Each accepted request gives exactly one strobe. Input changes while `req_ready_o` is 0 do not alter the byte on the bus.
- R10: When `req_pos_i` is 1, `req_data_i` is ignored and the byte goes out as a command (`lcd_rs_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_data_i | input | 1 | 1: character byte, 0: command byte |
| req_pos_i | input | 1 | 1: cursor move built from row and column |
| req_byte_i | input | 8 | Byte to send when not a cursor move |
| req_row_i | input | 1 | Cursor row (0 or 1) |
| req_col_i | input | COL_W | Cursor column, clamped to 15 |
| lcd_db_o | output | 8 | Display data bus |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 character |
| lcd_rw_o | output | 1 | Read/write, held at write (0) |
| lcd_en_o | output | 1 | Enable strobe; the display latches on its fall |

## Verification
The bench first runs the power-up sequence and then sends character bytes and plain commands. A bad register-select level shows up as a mismatch between these two kinds of byte. Cursor requests cover both rows, column 0, column 15 and columns 20 and 31. The last two separate clamping from wrap-around or truncation. One cursor request also sets the character flag, to show that the flag is ignored. Pairs of clear, return-home and a character 0x01 are sent back to back. The spacing of the strobes then separates the long wait from the normal one and shows that the choice depends on register select as well as on the byte value. One request is sent after an idle stretch and is not counted against the back-to-back spacing. The request byte is changed after every accepted request, which would expose a bus that is not latched.

// File: rtl/lcdw_pkg.sv
`timescale 1ns/1ps
package lcdw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_WAIT
  } phase_e;

  typedef struct packed {
    logic       rs;
    logic [7:0] code;
  } xfer_t;

  localparam int unsigned INIT_LEN  = 4;
  localparam logic [7:0]  CMD_CLEAR = 8'h01;
  localparam logic [7:0]  CMD_HOME  = 8'h02;
  localparam logic [7:0]  ROW0_BASE = 8'h80;
  localparam logic [7:0]  ROW1_BASE = 8'hC0;

  // power-up commands, issued in index order
  function automatic logic [7:0] init_code(input int unsigned idx);
    case (idx)
      0:       return 8'h38;
      1:       return 8'h0F;
      2:       return 8'h06;
      default: return CMD_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/lcdw_pos_enc.sv
`timescale 1ns/1ps
module lcdw_pos_enc
  import lcdw_pkg::*;
#(
  parameter int unsigned COLS  = 16,
  parameter int unsigned COL_W = 5
) (
  input  logic             row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [7:0]       code_o
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [COL_W-1:0] col_c;

  always_comb begin
    col_c  = (col_i > LAST_COL) ? LAST_COL : col_i;
    code_o = (row_i ? ROW1_BASE : ROW0_BASE) + 8'(col_c);
  end

endmodule

// File: rtl/lcdw_init_seq.sv
`timescale 1ns/1ps
module lcdw_init_seq
  import lcdw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  eng_idle_i,
  output logic  start_o,
  output xfer_t xfer_o,
  output logic  done_o
);

  localparam int unsigned IDX_W = $clog2(INIT_LEN + 1);

  logic [IDX_W-1:0] idx_q;

  assign done_o      = (idx_q == IDX_W'(INIT_LEN));
  assign start_o     = !done_o && eng_idle_i;
  assign xfer_o.rs   = 1'b0;
  assign xfer_o.code = init_code(int'(idx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_o) idx_q <= idx_q + 1'b1;
  end

endmodule

// File: rtl/lcdw_strobe.sv
`timescale 1ns/1ps
module lcdw_strobe
  import lcdw_pkg::*;
#(
  parameter int unsigned SETUP_CYC     = 2,
  parameter int unsigned PULSE_CYC     = 12,
  parameter int unsigned HOLD_CYC      = 2,
  parameter int unsigned WAIT_CYC      = 2000,
  parameter int unsigned LONG_WAIT_CYC = 80000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  xfer_t      xfer_i,
  output logic       idle_o,
  output logic [7:0] db_o,
  output logic       rs_o,
  output logic       en_o
);

  localparam int unsigned M0    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned M1    = (M0 > HOLD_CYC) ? M0 : HOLD_CYC;
  localparam int unsigned M2    = (M1 > WAIT_CYC) ? M1 : WAIT_CYC;
  localparam int unsigned MAXC  = (M2 > LONG_WAIT_CYC) ? M2 : LONG_WAIT_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WAIT  = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(LONG_WAIT_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  xfer_t            bus_q;
  logic             slow_cmd;
  logic             last;

  assign slow_cmd = !bus_q.rs && (bus_q.code == CMD_CLEAR || bus_q.code == CMD_HOME);
  assign last     = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_SETUP;
        cnt_d   = LD_SETUP;
      end
      PH_SETUP: if (last) begin
        phase_d = PH_PULSE;
        cnt_d   = LD_PULSE;
      end
      PH_PULSE: if (last) begin
        phase_d = PH_HOLD;
        cnt_d   = LD_HOLD;
      end
      PH_HOLD: if (last) begin
        phase_d = PH_WAIT;
        cnt_d   = slow_cmd ? LD_LONG : LD_WAIT;
      end
      PH_WAIT: if (last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bus_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (phase_q == PH_IDLE && start_i) bus_q <= xfer_i;
    end
  end

  assign idle_o = (phase_q == PH_IDLE);
  assign en_o   = (phase_q == PH_PULSE);
  assign db_o   = bus_q.code;
  assign rs_o   = bus_q.rs;

endmodule

// File: rtl/charlcd_writer.sv
`timescale 1ns/1ps
module charlcd_writer
  import lcdw_pkg::*;
#(
  parameter int unsigned COLS          = 16,
  parameter int unsigned COL_W         = 5,
  parameter int unsigned SETUP_CYC     = 2,
  parameter int unsigned PULSE_CYC     = 12,
  parameter int unsigned HOLD_CYC      = 2,
  parameter int unsigned WAIT_CYC      = 2000,
  parameter int unsigned LONG_WAIT_CYC = 80000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_data_i,
  input  logic             req_pos_i,
  input  logic [7:0]       req_byte_i,
  input  logic             req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  output logic [7:0]       lcd_db_o,
  output logic             lcd_rs_o,
  output logic             lcd_rw_o,
  output logic             lcd_en_o
);

  logic       eng_idle;
  logic       init_start, init_done;
  xfer_t      init_xfer, req_xfer, sel_xfer;
  logic [7:0] pos_code;
  logic       start;

  lcdw_init_seq u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eng_idle_i (eng_idle),
    .start_o    (init_start),
    .xfer_o     (init_xfer),
    .done_o     (init_done)
  );

  lcdw_pos_enc #(
    .COLS  (COLS),
    .COL_W (COL_W)
  ) u_pos (
    .row_i  (req_row_i),
    .col_i  (req_col_i),
    .code_o (pos_code)
  );

  assign req_ready_o = init_done && eng_idle;

  always_comb begin
    req_xfer.rs   = req_pos_i ? 1'b0 : req_data_i;
    req_xfer.code = req_pos_i ? pos_code : req_byte_i;
    sel_xfer      = init_done ? req_xfer : init_xfer;
    start         = init_done ? (req_valid_i && req_ready_o) : init_start;
  end

  lcdw_strobe #(
    .SETUP_CYC     (SETUP_CYC),
    .PULSE_CYC     (PULSE_CYC),
    .HOLD_CYC      (HOLD_CYC),
    .WAIT_CYC      (WAIT_CYC),
    .LONG_WAIT_CYC (LONG_WAIT_CYC)
  ) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .xfer_i  (sel_xfer),
    .idle_o  (eng_idle),
    .db_o    (lcd_db_o),
    .rs_o    (lcd_rs_o),
    .en_o    (lcd_en_o)
  );

  assign lcd_rw_o = 1'b0;

endmodule

// File: rtl/lcdw_checker.sv
`timescale 1ns/1ps
module lcdw_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [7:0] lcd_db_o,
  input logic       lcd_rs_o,
  input logic       lcd_rw_o,
  input logic       lcd_en_o
);

  assert_rw_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_rw_o == 1'b0);

  assert_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_en_o) |-> ($stable(lcd_db_o) && $stable(lcd_rs_o)));

  assert_pulse_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_en_o && $past(lcd_en_o)) |-> ($stable(lcd_db_o) && $stable(lcd_rs_o)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_en_o) |-> ($stable(lcd_db_o) && $stable(lcd_rs_o)));

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_en_o |-> !req_ready_o);

  assert_accept_drops_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

bind charlcd_writer lcdw_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .lcd_db_o    (lcd_db_o),
  .lcd_rs_o    (lcd_rs_o),
  .lcd_rw_o    (lcd_rw_o),
  .lcd_en_o    (lcd_en_o)
);

// File: tb/sim_charlcd_writer.sv
`timescale 1ns/1ps
module sim_charlcd_writer;

  localparam int S  = 2;
  localparam int P  = 3;
  localparam int H  = 2;
  localparam int W  = 4;
  localparam int LW = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid, data, pos, row;
  logic [7:0] byte_in;
  logic [4:0] col;
  logic       ready, rs, rw, en;
  logic [7:0] db;

  always #4 clk = ~clk;

  charlcd_writer #(
    .COLS(16), .COL_W(5), .SETUP_CYC(S), .PULSE_CYC(P),
    .HOLD_CYC(H), .WAIT_CYC(W), .LONG_WAIT_CYC(LW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_data_i(data), .req_pos_i(pos), .req_byte_i(byte_in),
    .req_row_i(row), .req_col_i(col), .lcd_db_o(db), .lcd_rs_o(rs),
    .lcd_rw_o(rw), .lcd_en_o(en)
  );

  int n_chk = 0;
  int n_err = 0;
  int pushed = 0;
  int pulses = 0;
  bit prev_long = 0;
  bit done = 0;

  logic [7:0] q_code[$];
  logic       q_rs[$];
  int         q_gap[$];
  string      q_tag[$];
  string      q_gtag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit e_rs, input logic [7:0] e_code,
                      input bit chained, input string tag);
    q_code.push_back(e_code);
    q_rs.push_back(e_rs);
    q_gap.push_back(chained ? (H + (prev_long ? LW : W) + 1 + S + P) : 0);
    q_gtag.push_back(prev_long ? "R8" : "R7");
    q_tag.push_back(tag);
    prev_long = !e_rs && (e_code == 8'h01 || e_code == 8'h02);
    pushed++;
  endtask

  task automatic send(input bit d, input bit p, input logic [7:0] b,
                      input bit r, input logic [4:0] c,
                      input logic [7:0] e_code, input bit chained,
                      input string tag);
    push(p ? 1'b0 : d, e_code, chained, tag);
    @(negedge clk);
    data = d; pos = p; byte_in = b; row = r; col = c; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(posedge clk);
    #1;
    valid = 1'b0;
    byte_in = ~b;         // R9: changes after acceptance must not reach the bus
    col = ~c;
    data = ~d;
  endtask

  // monitor: scoreboard pop on each strobe fall
  logic       prev_en = 1'b0;
  int         cyc = 0;
  int         last_fall = 0;
  int         hi_cnt = 0;
  logic [7:0] db_rise = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (en && !prev_en) begin
        db_rise = db;
        hi_cnt  = 0;
        chk(!ready, "R9", "ready during strobe", int'(ready), 0);
      end
      if (en) hi_cnt++;
      if (!en && prev_en) begin
        pulses++;
        if (q_code.size() == 0) begin
          chk(1'b0, "R9", "strobe with no pending request", int'(db), 0);
        end else begin
          automatic logic [7:0] e_code = q_code.pop_front();
          automatic logic       e_rs   = q_rs.pop_front();
          automatic int         e_gap  = q_gap.pop_front();
          automatic string      tag    = q_tag.pop_front();
          automatic string      gtag   = q_gtag.pop_front();
          chk(db == e_code, tag, "bus byte", int'(db), int'(e_code));
          chk(rs == e_rs, tag, "register select", int'(rs), int'(e_rs));
          chk(db_rise == db, "R4", "byte changed while strobe high", int'(db_rise), int'(db));
          chk(hi_cnt == P, "R4", "strobe width", hi_cnt, P);
          chk(rw == 1'b0, "R2", "read/write level", int'(rw), 0);
          if (e_gap != 0)
            chk(cyc - last_fall == e_gap, gtag, "strobe spacing", cyc - last_fall, e_gap);
        end
        last_fall = cyc;
      end
      prev_en = en;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; data = 1'b0; pos = 1'b0;
    byte_in = '0; row = 1'b0; col = '0;
    repeat (3) @(negedge clk);
    chk(en == 1'b0, "R4", "strobe in reset", int'(en), 0);
    chk(ready == 1'b0, "R3", "ready in reset", int'(ready), 0);
    chk(rw == 1'b0, "R2", "read/write in reset", int'(rw), 0);

    // R3: power-up commands
    push(1'b0, 8'h38, 1'b0, "R3");
    push(1'b0, 8'h0F, 1'b1, "R3");
    push(1'b0, 8'h06, 1'b1, "R3");
    push(1'b0, 8'h01, 1'b1, "R3");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R3", "ready during init", int'(ready), 0);

    send(1, 0, 8'h48, 0, 0,  8'h48, 1, "R1");
    send(0, 0, 8'h0C, 0, 0,  8'h0C, 1, "R1");
    send(0, 1, 8'h00, 0, 5,  8'h85, 1, "R5");
    send(0, 1, 8'h00, 1, 0,  8'hC0, 1, "R5");
    send(0, 1, 8'h00, 1, 15, 8'hCF, 1, "R5");
    send(1, 1, 8'h00, 1, 20, 8'hCF, 1, "R10");  // data flag ignored, column clamped
    send(0, 1, 8'h00, 0, 31, 8'h8F, 1, "R6");
    send(0, 0, 8'h01, 0, 0,  8'h01, 1, "R8");
    send(1, 0, 8'h41, 0, 0,  8'h41, 1, "R8");
    send(0, 0, 8'h02, 0, 0,  8'h02, 1, "R8");
    send(1, 0, 8'h01, 0, 0,  8'h01, 1, "R8");
    send(1, 0, 8'h5A, 0, 0,  8'h5A, 1, "R8");   // spacing normal: character 0x01 is not slow

    repeat (30) @(negedge clk);
    chk(ready == 1'b1, "R9", "ready when idle", int'(ready), 1);
    chk(en == 1'b0, "R9", "strobe when idle", int'(en), 0);
    send(1, 0, 8'h7E, 0, 0, 8'h7E, 0, "R1");

    repeat (40) @(negedge clk);
    chk(q_code.size() == 0, "R9", "pending items", q_code.size(), 0);
    chk(pulses == pushed, "R9", "strobe count", pulses, pushed);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule